// File: doc/BRIEF.md
# Decade Counter With Load-Based Wrap

This block counts in binary-coded decimal, one digit wide, from 0 up to 9 and back to 0. It is built as a 4-bit synchronous binary counter with a parallel load port. A small detector watches the counter and asserts the load request, and the parallel data inputs are tied to zero. When the digit reaches 9, the next enabled clock edge loads 0000 instead of incrementing. There is no compare-and-clear and no asynchronous clear.

The detector only looks at the least and most significant bits. Within the legal range 0..9, both bits are set only at 1001. A count enable gates both incrementing and loading. A terminal-count output marks the enabled cycle in which the digit sits at 9, so a following digit could use it as its enable. A synchronous reset overrides everything else.

Top module: `decade_counter`

## Requirements
- R1: With `rst` high at a rising edge, `digit` is 0000 after that edge, whatever `cnt_en` and the current value are. This includes the case where the digit is 9 and `cnt_en` is high.
- R2: With `rst` low and `cnt_en` high, a rising edge at any digit value 0 through 8 raises `digit` by exactly one.
- R3: With `rst` low, `cnt_en` high and `digit` equal to 1001 (nine), the next rising edge makes `digit` 0000.
- R4: With `rst` low and `cnt_en` low, a rising edge leaves `digit` unchanged, including when it is 1001.
- R5: `tc` is high, in the same cycle and without waiting for an edge, exactly when `digit` is 1001 and `cnt_en` is high. Otherwise it is low.
- R6: After reset, `digit` never holds any value from 1010 to 1111, whatever pattern `cnt_en` follows.
- R7: Starting from reset, ten enabled edges step `digit` through 1,2,...,9,0 in order, skipping and repeating nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; gates increment and wrap |
| digit | output | 4 | Current BCD digit, binary weighted |
| tc | output | 1 | Terminal count: digit is nine and enable is high |

## Verification
The bench targets the wrap at nine. A design that compared against the wrong value would either stop at eight or run on into 1010. A design that did not gate the load with the enable would fall to zero while meant to hold at nine. A second target is reset arriving on the very edge where a load is pending. If the load won over reset, the result would still be zero, so the bench also applies reset mid-count, where an increment would win instead. A third target is `tc` being driven while the enable is low, since that would wrongly advance a following digit.

// File: rtl/decade_pkg.sv
package decade_pkg;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] RELOAD_VAL = '0;
    localparam logic [DIGIT_W-1:0] LAST_DIGIT = DIGIT_W'(9);
endpackage

// File: rtl/dc_wrap_detect.sv
module dc_wrap_detect (
    input  logic lsb,
    input  logic msb,
    output logic hit
);
    // Within 0..9 the two outer bits are both set only at nine.
    always_comb begin
        hit = lsb & msb;
    end
endmodule

// File: rtl/dc_load_counter.sv
module dc_load_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         count,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.val = '0;
        end else if (load) begin
            state_d.val = din;
        end else if (count) begin
            state_d.val = state_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q = state_q.val;
endmodule

// File: rtl/decade_counter.sv
module decade_counter (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    output logic [3:0] digit,
    output logic       tc
);
    import decade_pkg::*;

    localparam int W = DIGIT_W;

    logic [W-1:0] cnt_q;
    logic         at_end;
    logic         load_req;

    dc_wrap_detect u_detect (
        .lsb (cnt_q[0]),
        .msb (cnt_q[W-1]),
        .hit (at_end)
    );

    // The load is qualified by the enable so a paused digit holds at nine.
    always_comb begin
        load_req = at_end & cnt_en;
    end

    dc_load_counter #(.W(W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .load  (load_req),
        .count (cnt_en),
        .din   (RELOAD_VAL),
        .q     (cnt_q)
    );

    assign digit = cnt_q;
    assign tc    = load_req;
endmodule

// File: rtl/decade_counter_chk.sv
module decade_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       cnt_en,
    input logic [3:0] digit,
    input logic       tc
);
    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> digit == 4'd0); // R1
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && digit != 4'd9) |=> digit == $past(digit) + 4'd1); // R2
    AST_WRAP_NINE: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && digit == 4'd9) |=> digit == 4'd0); // R3
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(digit)); // R4
    AST_TC_MATCH: assert property (@(posedge clk) disable iff (rst)
        tc == (cnt_en && digit == 4'd9)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        digit <= 4'd9); // R6
endmodule

bind decade_counter decade_counter_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .digit  (digit),
    .tc     (tc)
);

// File: tb/tb_decade_counter.sv
`timescale 1ns/1ps
module tb_decade_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] digit;
    logic       tc;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    decade_counter dut (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .digit  (digit),
        .tc     (tc)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive inputs 2 ns after an edge, then step to 2 ns after the next edge.
    task automatic step(input logic r, input logic e);
        rst = r;
        cnt_en = e;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        step(1'b1, 1'b0);
        chk("R1 reset value", digit, 0);
        chk("R5 tc low in reset idle", tc, 0);
    endtask

    task automatic t_full_cycle();
        step(1'b1, 1'b0);
        for (int i = 1; i <= 10; i++) begin
            step(1'b0, 1'b1);
            chk("R7 sequence", digit, i % 10);
            if (i < 10) chk("R2 increment", digit, i);
            else        chk("R3 wrap to zero", digit, 0);
        end
    endtask

    task automatic t_tc();
        step(1'b1, 1'b0);
        for (int i = 0; i < 9; i++) step(1'b0, 1'b1);
        chk("R5 at nine", digit, 9);
        cnt_en = 1'b1; #1;
        chk("R5 tc high with enable", tc, 1);
        cnt_en = 1'b0; #1;
        chk("R5 tc low without enable", tc, 0);
        step(1'b0, 1'b0);
        chk("R4 hold at nine", digit, 9);
        step(1'b0, 1'b0);
        chk("R4 hold at nine twice", digit, 9);
        step(1'b0, 1'b1);
        chk("R3 wrap after pause", digit, 0);
        cnt_en = 1'b1; #1;
        chk("R5 tc low at zero", tc, 0);
    endtask

    task automatic t_hold_mid();
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R4 hold mid", digit, 3);
        step(1'b0, 1'b1);
        chk("R2 resume", digit, 4);
    endtask

    task automatic t_reset_priority();
        step(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk("R1 reset over count", digit, 0);
        for (int i = 0; i < 9; i++) step(1'b0, 1'b1);
        chk("R2 reached nine", digit, 9);
        step(1'b1, 1'b1);
        chk("R1 reset over load", digit, 0);
    endtask

    task automatic t_range();
        int exp = 0;
        bit bad = 1'b0;
        step(1'b1, 1'b0);
        for (int i = 0; i < 60; i++) begin
            logic e = ((i * 7) % 5) != 0;
            step(1'b0, e);
            if (e) exp = (exp + 1) % 10;
            if (digit > 4'd9 || digit != exp) bad = 1'b1;
        end
        chk("R6 stays in range", int'(bad), 0);
        chk("R6 final digit", digit, exp);
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        t_full_cycle();
        t_tc();
        t_hold_mid();
        t_reset_priority();
        t_range();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule